// File: doc/BRIEF.md
# Tiled View Address Generator

This block turns a pixel coordinate into an address inside a tiled-memory container. The same buffer can be read in eight orientations. It takes a 2-bit pixel-format code, a 3-bit orientation code and an X/Y coordinate. It returns the container address for that pixel in that view, and the line stride of the view.

The format code picks how many coordinate bits are unused on each axis. That choice sets the legal coordinate range on each axis, how X and Y are packed into the offset, and how far left the packed offset is shifted. The orientation code mirrors either axis, can exchange the two axes, and is carried, together with the format code, in the top bits of the address. A coordinate outside the legal range for its format gives an all-zero address.

The container size, the page-mode slot size, the orientation bit positions and an optional output register are all parameters. With the default settings the address is 32 bits wide, and the result appears one clock after the input.

Top module: `tiled_addr_gen`

## Requirements
- R1: For an in-range coordinate, address bits [28:27] hold the format code: 0 = 8-bit tiled, 1 = 16-bit tiled, 2 = 32-bit tiled, 3 = page mode.
- R2: For an in-range coordinate, address bits [31:29] hold the orientation code exactly as given. Codes 0..7 mean 0°, 180° mirrored, 0° mirrored, 180°, 270° mirrored, 270°, 90°, 90° mirrored.
- R3: Each format has unused-bit shifts (xs, ys): 8-bit (0,0), 16-bit (0,1), 32-bit (1,1), page (6,6). X must not exceed 2^(14−xs)−1 and Y must not exceed 2^(13−ys)−1. If either does, the whole address is 0.
- R4: When orientation bit 0 is set, X is replaced by X XOR its full range mask.
- R5: When orientation bit 1 is set, Y is replaced by Y XOR its full range mask.
- R6: When orientation bit 2 is set, the offset is (X << (13−ys)) + Y. Otherwise it is (Y << (14−xs)) + X. The mirrored coordinates are used in both cases.
- R7: The offset is shifted left by xs+ys and then placed in address bits [26:0].
- R8: The stride is 2^(13+xs) when orientation bit 2 is set, and 2^(14+ys) otherwise.
- R9: With the output register enabled, out_valid, addr and stride appear one clock after in_valid is sampled high, and out_valid drops one clock after in_valid is sampled low. During reset, out_valid, addr and stride read 0.

Top module ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request strobe |
| fmt | input | 2 | Pixel-format code |
| orient | input | 3 | Orientation code |
| x_coord | input | 16 | Pixel X coordinate |
| y_coord | input | 16 | Pixel Y coordinate |
| out_valid | output | 1 | Result strobe |
| addr | output | 32 | Container address with format and orientation fields |
| stride | output | 32 | Line stride of the selected view |

## Verification
The bench goes after the range limits at each format's edge, such as a page-mode X of 255 against 256 and a 16-bit Y of 4096. A design that used the wrong mask there would either return a non-zero address or wrap the coordinate. Inverting both axes at once drives every offset bit high, so a mirror applied to the wrong axis, or a mask one bit short, shows up as a changed low address. The axis-swap codes are checked for offset and stride together, because a design that swaps the offset but not the stride, or shifts by the wrong axis width, gets one of the two wrong. A sweep over all four formats and all eight orientations guards the field placement and the alignment shift.

// File: rtl/tvag_pkg.sv
package tvag_pkg;
   typedef enum logic [1:0] {
      FMT_8B   = 2'd0,
      FMT_16B  = 2'd1,
      FMT_32B  = 2'd2,
      FMT_PAGE = 2'd3
   } pix_fmt_e;

   // unused low coordinate bits per axis for one format
   typedef struct packed {
      logic [4:0] xs;
      logic [4:0] ys;
   } geom_t;
endpackage

// File: rtl/tvag_geom.sv
module tvag_geom
   import tvag_pkg::*;
#(
   parameter int SLOT_W_BITS = 6,
   parameter int SLOT_H_BITS = 6
) (
   input  pix_fmt_e fmt,
   output geom_t    g
);
   always_comb begin
      unique case (fmt)
         FMT_8B:   g = '{xs: 5'd0, ys: 5'd0};
         FMT_16B:  g = '{xs: 5'd0, ys: 5'd1};
         FMT_32B:  g = '{xs: 5'd1, ys: 5'd1};
         default:  g = '{xs: 5'(SLOT_W_BITS), ys: 5'(SLOT_H_BITS)};
      endcase
   end
endmodule

// File: rtl/tvag_xform.sv
module tvag_xform
   import tvag_pkg::*;
#(
   parameter int CW_BITS  = 14,
   parameter int CH_BITS  = 13,
   parameter int COORD_W  = 16,
   parameter int STRIDE_W = 32,
   parameter int XINV_POS = 0,
   parameter int YINV_POS = 1,
   parameter int SWAP_POS = 2
) (
   input  geom_t                        g,
   input  logic [2:0]                   orient,
   input  logic [COORD_W-1:0]           x_in,
   input  logic [COORD_W-1:0]           y_in,
   output logic                         in_range,
   output logic [CW_BITS+CH_BITS-1:0]   offset,
   output logic [STRIDE_W-1:0]          stride
);
   localparam int AW = CW_BITS + CH_BITS;

   logic [5:0]    xb, yb, al, sh_stride;
   logic [AW-1:0] xmask, ymask, xe, ye, xm, ym, lin;

   always_comb begin
      xb    = 6'(CW_BITS) - 6'(g.xs);
      yb    = 6'(CH_BITS) - 6'(g.ys);
      al    = 6'(g.xs) + 6'(g.ys);
      xmask = (AW'(1) << xb) - AW'(1);
      ymask = (AW'(1) << yb) - AW'(1);
      xe    = AW'(x_in);
      ye    = AW'(y_in);
      in_range = (xe <= xmask) && (ye <= ymask);
      xm    = orient[XINV_POS] ? (xe ^ xmask) : xe;
      ym    = orient[YINV_POS] ? (ye ^ ymask) : ye;
      lin   = orient[SWAP_POS] ? ((xm << yb) + ym) : ((ym << xb) + xm);
      offset = lin << al;
      sh_stride = orient[SWAP_POS] ? (6'(CH_BITS) + 6'(g.xs))
                                   : (6'(CW_BITS) + 6'(g.ys));
      stride = STRIDE_W'(1) << sh_stride;
   end
endmodule

// File: rtl/tiled_addr_gen.sv
module tiled_addr_gen
   import tvag_pkg::*;
#(
   parameter int CW_BITS     = 14,
   parameter int CH_BITS     = 13,
   parameter int SLOT_W_BITS = 6,
   parameter int SLOT_H_BITS = 6,
   parameter int COORD_W     = 16,
   parameter int STRIDE_W    = 32,
   parameter int XINV_POS    = 0,
   parameter int YINV_POS    = 1,
   parameter int SWAP_POS    = 2,
   parameter bit REG_OUT     = 1'b1,
   localparam int AW         = CW_BITS + CH_BITS,
   localparam int ADDR_W     = AW + 5
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                in_valid,
   input  logic [1:0]          fmt,
   input  logic [2:0]          orient,
   input  logic [COORD_W-1:0]  x_coord,
   input  logic [COORD_W-1:0]  y_coord,
   output logic                out_valid,
   output logic [ADDR_W-1:0]   addr,
   output logic [STRIDE_W-1:0] stride
);
   // elaboration-time parameter checks
   if (COORD_W > AW) begin : g_bad_coord
      $error("COORD_W must not exceed CW_BITS+CH_BITS");
   end
   if (SLOT_W_BITS > CW_BITS || SLOT_H_BITS > CH_BITS) begin : g_bad_slot
      $error("slot bits exceed container bits");
   end
   if (XINV_POS == YINV_POS || XINV_POS == SWAP_POS || YINV_POS == SWAP_POS ||
       XINV_POS > 2 || YINV_POS > 2 || SWAP_POS > 2) begin : g_bad_pos
      $error("orientation bit positions must be distinct and below 3");
   end
   if (STRIDE_W < CW_BITS + SLOT_H_BITS + 1 || STRIDE_W < CH_BITS + SLOT_W_BITS + 1)
   begin : g_bad_stride
      $error("STRIDE_W too narrow for largest stride");
   end

   pix_fmt_e           fmt_e;
   geom_t              geo;
   logic               rng_ok;
   logic [AW-1:0]      off;
   logic [STRIDE_W-1:0] stride_c;
   logic [ADDR_W-1:0]  addr_c;

   assign fmt_e = pix_fmt_e'(fmt);

   tvag_geom #(
      .SLOT_W_BITS (SLOT_W_BITS),
      .SLOT_H_BITS (SLOT_H_BITS)
   ) u_geom (
      .fmt (fmt_e),
      .g   (geo)
   );

   tvag_xform #(
      .CW_BITS  (CW_BITS),
      .CH_BITS  (CH_BITS),
      .COORD_W  (COORD_W),
      .STRIDE_W (STRIDE_W),
      .XINV_POS (XINV_POS),
      .YINV_POS (YINV_POS),
      .SWAP_POS (SWAP_POS)
   ) u_xform (
      .g        (geo),
      .orient   (orient),
      .x_in     (x_coord),
      .y_in     (y_coord),
      .in_range (rng_ok),
      .offset   (off),
      .stride   (stride_c)
   );

   assign addr_c = rng_ok ? {orient, fmt, off} : '0;

   if (REG_OUT) begin : g_reg
      logic                vld_q;
      logic [ADDR_W-1:0]   addr_q;
      logic [STRIDE_W-1:0] stride_q;
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            vld_q    <= 1'b0;
            addr_q   <= '0;
            stride_q <= '0;
         end else begin
            vld_q <= in_valid;
            if (in_valid) begin
               addr_q   <= addr_c;
               stride_q <= stride_c;
            end
         end
      end
      assign out_valid = vld_q;
      assign addr      = addr_q;
      assign stride    = stride_q;
   end else begin : g_comb
      assign out_valid = in_valid;
      assign addr      = addr_c;
      assign stride    = stride_c;
   end
endmodule

// File: rtl/tvag_chk.sv
module tvag_chk #(
   parameter int CW_BITS     = 14,
   parameter int CH_BITS     = 13,
   parameter int SLOT_W_BITS = 6,
   parameter int SLOT_H_BITS = 6,
   parameter int COORD_W     = 16,
   parameter int STRIDE_W    = 32,
   parameter bit REG_OUT     = 1'b1,
   localparam int AW         = CW_BITS + CH_BITS,
   localparam int ADDR_W     = AW + 5
) (
   input logic                clk,
   input logic                rst_n,
   input logic                in_valid,
   input logic [1:0]          fmt,
   input logic [2:0]          orient,
   input logic [COORD_W-1:0]  x_coord,
   input logic [COORD_W-1:0]  y_coord,
   input logic                out_valid,
   input logic [ADDR_W-1:0]   addr,
   input logic [STRIDE_W-1:0] stride
);
   function automatic longint lim(input int bits_c, input int unused_b);
      return (longint'(1) << (bits_c - unused_b)) - 1;
   endfunction

   int  xs_c, ys_c;
   logic rng;
   always_comb begin
      case (fmt)
         2'd0:    begin xs_c = 0; ys_c = 0; end
         2'd1:    begin xs_c = 0; ys_c = 1; end
         2'd2:    begin xs_c = 1; ys_c = 1; end
         default: begin xs_c = SLOT_W_BITS; ys_c = SLOT_H_BITS; end
      endcase
      rng = (longint'(x_coord) <= lim(CW_BITS, xs_c)) &&
            (longint'(y_coord) <= lim(CH_BITS, ys_c));
   end

   if (REG_OUT) begin : g_seq
      // R9
      valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
         in_valid |=> out_valid);
      // R9
      valid_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
         !in_valid |=> !out_valid);
      // R1
      fmt_field_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (in_valid && rng) |=> addr[AW+1:AW] == $past(fmt));
      // R2
      orient_field_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (in_valid && rng) |=> addr[AW+4:AW+2] == $past(orient));
      // R3
      range_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (in_valid && !rng) |=> addr == '0);
      // R8
      stride_pow2_chk: assert property (@(posedge clk) disable iff (!rst_n)
         out_valid |-> $countones(stride) == 1);
   end else begin : g_cmb
      // R1
      fmt_field_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (in_valid && rng) |-> addr[AW+1:AW] == fmt);
      // R2
      orient_field_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (in_valid && rng) |-> addr[AW+4:AW+2] == orient);
      // R3
      range_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (in_valid && !rng) |-> addr == '0);
      // R8
      stride_pow2_chk: assert property (@(posedge clk) disable iff (!rst_n)
         in_valid |-> $countones(stride) == 1);
   end
endmodule

bind tiled_addr_gen tvag_chk #(
   .CW_BITS     (CW_BITS),
   .CH_BITS     (CH_BITS),
   .SLOT_W_BITS (SLOT_W_BITS),
   .SLOT_H_BITS (SLOT_H_BITS),
   .COORD_W     (COORD_W),
   .STRIDE_W    (STRIDE_W),
   .REG_OUT     (REG_OUT)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .in_valid  (in_valid),
   .fmt       (fmt),
   .orient    (orient),
   .x_coord   (x_coord),
   .y_coord   (y_coord),
   .out_valid (out_valid),
   .addr      (addr),
   .stride    (stride)
);

// File: tb/tiled_addr_gen_tb.sv
`timescale 1ns/1ps
module tiled_addr_gen_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [1:0]  fmt = '0;
   logic [2:0]  orient = '0;
   logic [15:0] x_coord = '0;
   logic [15:0] y_coord = '0;
   logic        out_valid;
   logic [31:0] addr;
   logic [31:0] stride;

   int total = 0;
   int bad   = 0;

   always #2 clk = ~clk;   // 250 MHz

   tiled_addr_gen u_dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (in_valid),
      .fmt       (fmt),
      .orient    (orient),
      .x_coord   (x_coord),
      .y_coord   (y_coord),
      .out_valid (out_valid),
      .addr      (addr),
      .stride    (stride)
   );

   typedef struct packed {
      logic [1:0]  f;
      logic [2:0]  o;
      logic [15:0] x;
      logic [15:0] y;
      logic [31:0] a;
      logic [31:0] s;
   } vec_t;

   localparam int NV = 10;
   localparam vec_t VT [NV] = '{
      '{2'd0, 3'd0, 16'd1,    16'd1,    32'h0000_4001, 32'h0000_4000}, // R6 plain packing
      '{2'd2, 3'd0, 16'd1,    16'd0,    32'h1000_0004, 32'h0000_8000}, // R7 align by 2
      '{2'd0, 3'd1, 16'd0,    16'd0,    32'h2000_3FFF, 32'h0000_4000}, // R4 X mirror
      '{2'd0, 3'd2, 16'd0,    16'd0,    32'h47FF_C000, 32'h0000_4000}, // R5 Y mirror
      '{2'd0, 3'd4, 16'd1,    16'd2,    32'h8000_2002, 32'h0000_2000}, // R6 swap
      '{2'd1, 3'd0, 16'd0,    16'd4096, 32'h0000_0000, 32'h0000_8000}, // R3 y over
      '{2'd3, 3'd0, 16'd256,  16'd0,    32'h0000_0000, 32'h0010_0000}, // R3 x over
      '{2'd3, 3'd0, 16'd255,  16'd127,  32'h1FFF_F000, 32'h0010_0000}, // R1 page edge
      '{2'd2, 3'd4, 16'd0,    16'd0,    32'h9000_0000, 32'h0000_4000}, // R8 swap stride
      '{2'd1, 3'd3, 16'd0,    16'd0,    32'h6FFF_FFFE, 32'h0000_8000}  // R4 R5 both
   };

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic void shifts(input int f, output int xs, output int ys);
      case (f)
         0: begin xs = 0; ys = 0; end
         1: begin xs = 0; ys = 1; end
         2: begin xs = 1; ys = 1; end
         default: begin xs = 6; ys = 6; end
      endcase
   endfunction

   function automatic logic [31:0] ref_addr(input int f, input int o, input longint x, input longint y);
      int xs, ys, xb, yb;
      longint xm, ym, lin, r;
      shifts(f, xs, ys);
      xb = 14 - xs;
      yb = 13 - ys;
      xm = (longint'(1) << xb) - 1;
      ym = (longint'(1) << yb) - 1;
      if (x > xm || y > ym) return 32'd0;
      if ((o & 1) != 0) x = x ^ xm;
      if ((o & 2) != 0) y = y ^ ym;
      lin = ((o & 4) != 0) ? ((x << yb) + y) : ((y << xb) + x);
      r = (longint'(o) << 29) | (longint'(f) << 27) | (lin << (xs + ys));
      return r[31:0];
   endfunction

   function automatic logic [31:0] ref_stride(input int f, input int o);
      int xs, ys;
      shifts(f, xs, ys);
      return ((o & 4) != 0) ? (32'd1 << (13 + xs)) : (32'd1 << (14 + ys));
   endfunction

   task automatic drive(input int f, input int o, input int x, input int y);
      @(negedge clk);
      fmt      = 2'(f);
      orient   = 3'(o);
      x_coord  = 16'(x);
      y_coord  = 16'(y);
      in_valid = 1'b1;
      @(negedge clk);   // one register stage later
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      bad++;
      total++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      // R9 reset state
      repeat (3) @(negedge clk);
      chk("R9 reset valid", {31'd0, out_valid}, 32'd0);
      chk("R9 reset addr", addr, 32'd0);
      chk("R9 reset stride", stride, 32'd0);
      @(negedge clk);
      rst_n = 1'b1;

      // vector table
      for (int i = 0; i < NV; i++) begin
         drive(int'(VT[i].f), int'(VT[i].o), int'(VT[i].x), int'(VT[i].y));
         chk($sformatf("R1/R2/R3/R4/R5/R6/R7 table %0d addr", i), addr, VT[i].a);
         chk($sformatf("R8 table %0d stride", i), stride, VT[i].s);
         chk("R9 valid after request", {31'd0, out_valid}, 32'd1);
      end

      // sweep every format and orientation against the reference model
      for (int f = 0; f < 4; f++) begin
         for (int o = 0; o < 8; o++) begin
            int xs, ys, xmax, ymax, xv, yv;
            shifts(f, xs, ys);
            xmax = (1 << (14 - xs)) - 1;
            ymax = (1 << (13 - ys)) - 1;
            xv = (xmax * 3) / 7 + o;
            yv = ymax / 5 + f;
            drive(f, o, xv, yv);
            chk($sformatf("R2 R7 sweep f%0d o%0d addr", f, o), addr, ref_addr(f, o, xv, yv));
            chk($sformatf("R8 sweep f%0d o%0d stride", f, o), stride, ref_stride(f, o));
            drive(f, o, xmax, 0);
            chk($sformatf("R1 R3 edge f%0d o%0d addr", f, o), addr, ref_addr(f, o, xmax, 0));
            drive(f, o, 0, ymax + 1);
            chk($sformatf("R3 over f%0d o%0d addr", f, o), addr, 32'd0);
         end
      end

      // R9 valid drop and hold of last result
      drive(0, 0, 5, 6);
      chk("R9 pre-drop addr", addr, ref_addr(0, 0, 5, 6));
      @(negedge clk);
      in_valid = 1'b0;
      x_coord  = 16'd100;
      @(negedge clk);
      chk("R9 valid drop", {31'd0, out_valid}, 32'd0);
      in_valid = 1'b1;
      @(negedge clk);
      chk("R9 valid return", {31'd0, out_valid}, 32'd1);
      chk("R9 new addr", addr, ref_addr(0, 0, 100, 6));
      in_valid = 1'b0;
      @(negedge clk);

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule